// File: doc/BRIEF.md
# MSI Capability Register Decoder

This block holds the message-signalled-interrupt capability structure of one emulated PCI function. Configuration-space writes arrive as an absolute offset, a byte length (1, 2 or 4) and data whose least significant byte belongs to the addressed offset. The capability starts at a programmable base offset. Two strap inputs say whether the function supports 64-bit message addresses and per-vector masking, and a third gives the number of vectors it can request. The straps decide where each register sits inside the capability.

When software sets the enable bit, the block checks the message that has been programmed. It also checks again when software rewrites the address or the data while the function is enabled. A message that passes is published as a base vector, a vector count, a destination mode, a delivery mode and a destination ID. Any rule violation sets a sticky error flag. A combinational read port returns any register by its start offset.

A two-state machine runs the block. In ST_IDLE it waits. The transition T_ACCEPT goes to ST_EVAL on any accepted write that needs a check: every control write, and any address or data write made while enabled. ST_EVAL lasts one cycle. In it the block either publishes the result, flags an error or drops the published enable. It then takes T_DONE back to ST_IDLE, or takes T_ACCEPT again if a further qualifying write lands in that same cycle.

Top module: `msi_cap_decoder`

## Requirements
- R1: After reset the published enable, vector, count, destination mode, delivery mode and destination ID are all zero and the error flag is clear. The control word reads back with enable 0, and the capability length reflects the straps.
- R2: The control word sits at base+2 with this layout: bit 0 is enable, bits 3:1 are the capable vector count, bits 6:4 are the enabled vector count, bit 7 means 64-bit capable and bit 8 means masking capable. Only bit 0 and bits 6:4 are writable. The other bits read back the straps.
- R3: Address-low sits at base+4. With 64-bit support, address-high is at base+8, data at base+0xC, mask at base+0x10 and pending at base+0x14. Without it, data is at base+8, mask at base+0xC and pending at base+0x10. Mask and pending exist only with masking support, and pending reads as zero. The capability length is 10 bytes, plus 4 with 64-bit support, plus 10 with masking support.
- R4: A write is refused, and leaves every register unchanged, if any of these holds: it lies below base+2; it targets the control word with a length other than 2; it targets an address register while enabled with a length other than 4; it targets data while enabled with a length below 2; it targets mask with a length other than 4; it targets pending or any offset that is not a register start. A refused write sets the error flag.
- R5: When enabled, the message fails its check if any of these holds: the enabled count exceeds the capable count; address-high is nonzero (64-bit only); address bits 31:20 are not 0xFEE; any of address bits 1:0 or 11:4 is set; the vector (data bits 7:0) lies outside 0x10..0xFE; the delivery mode (data bits 10:8) is above 1; the trigger bit (data bit 15) is set. A failure sets the error flag and leaves every published output unchanged.
- R6: A passing message publishes the following: the base vector from data bits 7:0; the delivery mode from data bits 10:8; the destination ID from address bits 19:12; a vector count of 2 to the power of the enabled count. The destination mode is logical (1) only when address bits 2 and 3 are both set, and physical (0) otherwise.
- R7: Take a write sampled on clock edge k. The published outputs and the error flag from the check change on edge k+1, and not on edge k.
- R8: A control write with enable 0 clears the published enable without any check and keeps the other published fields.
- R9: While enabled, an accepted address or data write triggers a new check. A pass republishes all fields.
- R10: While enabled, a data write whose vector differs from the vector held at the last control write or accepted data write is refused as in R4.
- R11: The error flag stays set until the clear input is applied in a cycle with no new error. A new error in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_base | input | 8 | Configuration offset of the capability start |
| strap_is64 | input | 1 | Function supports 64-bit message address |
| strap_mask | input | 1 | Function supports per-vector masking |
| strap_mmc | input | 3 | Capable vector count exponent |
| wr_en | input | 1 | Configuration write strobe |
| wr_off | input | 8 | Absolute configuration offset of the write |
| wr_len | input | 3 | Write length in bytes (1, 2 or 4) |
| wr_data | input | 32 | Write data, byte 0 at wr_off |
| rd_off | input | 8 | Absolute configuration offset to read |
| rd_data | output | 32 | Register starting at rd_off, zero elsewhere |
| err_clr | input | 1 | Clears the sticky error flag |
| cap_len | output | 5 | Capability length in bytes |
| msi_en | output | 1 | Published enable |
| base_vec | output | 8 | Published base vector |
| vec_cnt | output | 8 | Published vector count |
| dest_logical | output | 1 | Published destination mode, 1 = logical |
| del_mode | output | 3 | Published delivery mode |
| dest_id | output | 8 | Published destination ID |
| cfg_err | output | 1 | Sticky error flag |

## Verification
The main function is exercised first with a valid logical-destination message and then with address and data rewrites while enabled. Comparing these shows that the block re-checks on every enabled write and that the destination-mode rule needs both address bits. Each check rule is then broken on its own: count overflow, wrong header, must-be-zero bits, vectors 0x0F and 0xFF, delivery mode 2, level trigger and a nonzero upper address. The vector limit is also passed at 0xFE and 0x10, which separates an off-by-one from a correct range. Running with both strap configurations and two base offsets shows that register placement follows the 64-bit bit and the base.

// File: rtl/msi_cfg_pkg.sv
`timescale 1ns/1ps
package msi_cfg_pkg;
    typedef enum logic [0:0] {ST_IDLE, ST_EVAL} dec_state_e;

    typedef enum logic [2:0] {
        RG_NONE, RG_CTL, RG_ALO, RG_AHI, RG_DAT, RG_MSK, RG_PND
    } reg_sel_e;

    localparam logic [11:0] ADDR_HDR = 12'hFEE;
    localparam logic [7:0]  VEC_LO   = 8'h10;
    localparam logic [7:0]  VEC_HI   = 8'hFE;
    localparam int          LEN_BASE = 10;
    localparam int          LEN_W64  = 4;
    localparam int          LEN_MSK  = 10;
endpackage

// File: rtl/msi_cfg_regs.sv
`timescale 1ns/1ps
module msi_cfg_regs
    import msi_cfg_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cap_base,
    input  logic          strap_is64,
    input  logic          strap_mask,
    input  logic [2:0]    strap_mmc,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_off,
    input  logic [2:0]    wr_len,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_off,
    output logic [31:0]   rd_data,
    output logic          ctl_en,
    output logic [2:0]    ctl_mme,
    output logic [31:0]   addr_lo,
    output logic [31:0]   addr_hi,
    output logic [15:0]   msg_data,
    output logic          wr_eval,
    output logic          wr_bad
);
    localparam int CTL_REL = 2;

    logic [31:0] mask_q;
    logic [7:0]  vec_cache;
    logic        wr_ok;
    reg_sel_e    wsel, rsel;

    function automatic reg_sel_e find_reg(input logic [AW-1:0] off,
                                          input logic [AW-1:0] base,
                                          input logic w64, input logic msk);
        logic [AW-1:0] rel;
        logic          below;
        reg_sel_e      r;
        below = ({1'b0, off} < ({1'b0, base} + (AW+1)'(CTL_REL)));
        rel   = off - base;
        r     = RG_NONE;
        if (!below) begin
            if (rel == AW'(2))       r = RG_CTL;
            else if (rel == AW'(4))  r = RG_ALO;
            else if (w64) begin
                if (rel == AW'(8))              r = RG_AHI;
                else if (rel == AW'(12))        r = RG_DAT;
                else if (msk && rel == AW'(16)) r = RG_MSK;
                else if (msk && rel == AW'(20)) r = RG_PND;
            end else begin
                if (rel == AW'(8))              r = RG_DAT;
                else if (msk && rel == AW'(12)) r = RG_MSK;
                else if (msk && rel == AW'(16)) r = RG_PND;
            end
        end
        return r;
    endfunction

    function automatic logic [31:0] merge(input logic [31:0] old,
                                          input logic [31:0] nw,
                                          input logic [2:0] len);
        if (len == 3'd1)      return {old[31:8], nw[7:0]};
        else if (len == 3'd2) return {old[31:16], nw[15:0]};
        else                  return nw;
    endfunction

    assign wsel = find_reg(wr_off, cap_base, strap_is64, strap_mask);
    assign rsel = find_reg(rd_off, cap_base, strap_is64, strap_mask);

    always_comb begin
        wr_ok   = 1'b0;
        wr_eval = 1'b0;
        if (wr_en) begin
            unique case (wsel)
                RG_CTL: begin
                    wr_ok   = (wr_len == 3'd2);
                    wr_eval = wr_ok;
                end
                RG_ALO, RG_AHI: begin
                    wr_ok   = !ctl_en || (wr_len == 3'd4);
                    wr_eval = wr_ok && ctl_en;
                end
                RG_DAT: begin
                    wr_ok   = !ctl_en || (wr_len >= 3'd2 && wr_data[7:0] == vec_cache);
                    wr_eval = wr_ok && ctl_en;
                end
                RG_MSK:  wr_ok = (wr_len == 3'd4);
                default: wr_ok = 1'b0;
            endcase
        end
    end
    assign wr_bad = wr_en && !wr_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_en    <= 1'b0;
            ctl_mme   <= 3'd0;
            addr_lo   <= '0;
            addr_hi   <= '0;
            msg_data  <= '0;
            mask_q    <= '0;
            vec_cache <= '0;
        end else if (wr_ok) begin
            unique case (wsel)
                RG_CTL: begin
                    ctl_en    <= wr_data[0];
                    ctl_mme   <= wr_data[6:4];
                    vec_cache <= msg_data[7:0];
                end
                RG_ALO: addr_lo <= merge(addr_lo, wr_data, wr_len);
                RG_AHI: addr_hi <= merge(addr_hi, wr_data, wr_len);
                RG_DAT: begin
                    msg_data <= (wr_len == 3'd1) ? {msg_data[15:8], wr_data[7:0]} : wr_data[15:0];
                    if (ctl_en) vec_cache <= wr_data[7:0];
                end
                RG_MSK:  mask_q <= wr_data;
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (rsel)
            RG_CTL:  rd_data = {16'h0, 7'h0, strap_mask, strap_is64, ctl_mme, strap_mmc, ctl_en};
            RG_ALO:  rd_data = addr_lo;
            RG_AHI:  rd_data = addr_hi;
            RG_DAT:  rd_data = {16'h0, msg_data};
            RG_MSK:  rd_data = mask_q;
            default: rd_data = '0;
        endcase
    end

    // R4
    wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_eval, wr_bad}));
endmodule

// File: rtl/msi_msg_check.sv
`timescale 1ns/1ps
module msi_msg_check
    import msi_cfg_pkg::*;
(
    input  logic [2:0]  mme,
    input  logic [2:0]  mmc,
    input  logic        is64,
    input  logic [31:0] alo,
    input  logic [31:0] ahi,
    input  logic [15:0] dat,
    output logic        ok,
    output logic [7:0]  vec,
    output logic [7:0]  cnt,
    output logic        logical,
    output logic [2:0]  del,
    output logic [7:0]  dest
);
    logic cnt_bad, hi_bad, hdr_bad, mbz_bad, vec_bad, del_bad, trig_bad;

    always_comb begin
        cnt_bad  = (mme > mmc);
        hi_bad   = is64 && (ahi != 32'h0);
        hdr_bad  = (alo[31:20] != ADDR_HDR);
        mbz_bad  = (alo[1:0] != 2'b00) || (alo[11:4] != 8'h00);
        vec_bad  = (dat[7:0] < VEC_LO) || (dat[7:0] > VEC_HI);
        del_bad  = (dat[10:8] > 3'd1);
        trig_bad = dat[15];
        ok       = !(cnt_bad | hi_bad | hdr_bad | mbz_bad | vec_bad | del_bad | trig_bad);
        vec      = dat[7:0];
        cnt      = 8'd1 << mme;
        logical  = alo[3] & alo[2];
        del      = dat[10:8];
        dest     = alo[19:12];
    end
endmodule

// File: rtl/msi_cap_decoder.sv
`timescale 1ns/1ps
module msi_cap_decoder
    import msi_cfg_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] cap_base,
    input  logic          strap_is64,
    input  logic          strap_mask,
    input  logic [2:0]    strap_mmc,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_off,
    input  logic [2:0]    wr_len,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_off,
    output logic [31:0]   rd_data,
    input  logic          err_clr,
    output logic [4:0]    cap_len,
    output logic          msi_en,
    output logic [7:0]    base_vec,
    output logic [7:0]    vec_cnt,
    output logic          dest_logical,
    output logic [2:0]    del_mode,
    output logic [7:0]    dest_id,
    output logic          cfg_err
);
    dec_state_e  state_q, state_d;
    logic        ctl_en, wr_eval, wr_bad, chk_ok, err_set;
    logic [2:0]  ctl_mme, c_del;
    logic [31:0] addr_lo, addr_hi;
    logic [15:0] msg_data;
    logic [7:0]  c_vec, c_cnt, c_dest;
    logic        c_logical;

    assign cap_len = 5'(LEN_BASE) + (strap_is64 ? 5'(LEN_W64) : 5'd0)
                   + (strap_mask ? 5'(LEN_MSK) : 5'd0);

    msi_cfg_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .cap_base(cap_base),
        .strap_is64(strap_is64), .strap_mask(strap_mask), .strap_mmc(strap_mmc),
        .wr_en(wr_en), .wr_off(wr_off), .wr_len(wr_len), .wr_data(wr_data),
        .rd_off(rd_off), .rd_data(rd_data),
        .ctl_en(ctl_en), .ctl_mme(ctl_mme), .addr_lo(addr_lo), .addr_hi(addr_hi),
        .msg_data(msg_data), .wr_eval(wr_eval), .wr_bad(wr_bad)
    );

    msi_msg_check u_chk (
        .mme(ctl_mme), .mmc(strap_mmc), .is64(strap_is64),
        .alo(addr_lo), .ahi(addr_hi), .dat(msg_data),
        .ok(chk_ok), .vec(c_vec), .cnt(c_cnt), .logical(c_logical),
        .del(c_del), .dest(c_dest)
    );

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = wr_eval ? ST_EVAL : ST_IDLE;
            ST_EVAL: state_d = wr_eval ? ST_EVAL : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign err_set = wr_bad || (state_q == ST_EVAL && ctl_en && !chk_ok);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            msi_en       <= 1'b0;
            base_vec     <= '0;
            vec_cnt      <= '0;
            dest_logical <= 1'b0;
            del_mode     <= '0;
            dest_id      <= '0;
            cfg_err      <= 1'b0;
        end else begin
            if (err_set)      cfg_err <= 1'b1;
            else if (err_clr) cfg_err <= 1'b0;
            unique case (state_q)
                ST_EVAL: begin
                    if (!ctl_en) begin
                        msi_en <= 1'b0;
                    end else if (chk_ok) begin
                        msi_en       <= 1'b1;
                        base_vec     <= c_vec;
                        vec_cnt      <= c_cnt;
                        dest_logical <= c_logical;
                        del_mode     <= c_del;
                        dest_id      <= c_dest;
                    end
                end
                default: ;
            endcase
        end
    end

    // R5
    pub_vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_en |-> (base_vec >= VEC_LO && base_vec <= VEC_HI));
    // R5
    pub_del_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_en |-> del_mode <= 3'd1);
    // R6
    cnt_pow2_chk: assert property (@(posedge clk) disable iff (!rst_n)
        msi_en |-> $countones(vec_cnt) == 1);
    // R7
    rise_after_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(msi_en) |-> $past(state_q == ST_EVAL));
    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err && !err_clr |=> cfg_err);
endmodule

// File: tb/sim_msi_cap_decoder.sv
`timescale 1ns/1ps
module sim_msi_cap_decoder;
    typedef struct packed {
        logic       en;
        logic [7:0] vec;
        logic [7:0] cnt;
        logic       lg;
        logic [2:0] del;
        logic [7:0] id;
        logic       err;
    } pub_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cap_base = 8'h40;
    logic        strap_is64 = 1'b0, strap_mask = 1'b1;
    logic [2:0]  strap_mmc = 3'd2;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_off = '0;
    logic [2:0]  wr_len = '0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rd_off = '0;
    logic [31:0] rd_data;
    logic        err_clr = 1'b0;
    logic [4:0]  cap_len;
    logic        msi_en, dest_logical, cfg_err;
    logic [7:0]  base_vec, vec_cnt, dest_id;
    logic [2:0]  del_mode;

    int   n_chk = 0, n_fail = 0;
    bit   done = 0;
    string req_q[$];
    pub_t  exp_q[$];

    always #4 clk = ~clk;

    msi_cap_decoder u0 (
        .clk(clk), .rst_n(rst_n), .cap_base(cap_base), .strap_is64(strap_is64),
        .strap_mask(strap_mask), .strap_mmc(strap_mmc), .wr_en(wr_en), .wr_off(wr_off),
        .wr_len(wr_len), .wr_data(wr_data), .rd_off(rd_off), .rd_data(rd_data),
        .err_clr(err_clr), .cap_len(cap_len), .msi_en(msi_en), .base_vec(base_vec),
        .vec_cnt(vec_cnt), .dest_logical(dest_logical), .del_mode(del_mode),
        .dest_id(dest_id), .cfg_err(cfg_err)
    );

    function automatic pub_t act_pub();
        return {msi_en, base_vec, vec_cnt, dest_logical, del_mode, dest_id, cfg_err};
    endfunction

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (exp_q.size() > 0) begin
                pub_t  e, a;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                a = act_pub();
                n_chk++;
                if (a !== e) begin
                    n_fail++;
                    $display("FAIL %s published act=%h exp=%h", r, a, e);
                end
            end
        end
    end

    task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", r, act, exp);
        end
    endtask

    task automatic expect_pub(input string r, input logic en, input logic [7:0] vec,
                              input logic [7:0] cnt, input logic lg, input logic [2:0] del,
                              input logic [7:0] id, input logic err);
        req_q.push_back(r);
        exp_q.push_back({en, vec, cnt, lg, del, id, err});
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic cfg_wr(input logic [7:0] off, input logic [2:0] len, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_off = off; wr_len = len; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string r, input logic [7:0] off, input logic [31:0] exp);
        @(negedge clk);
        rd_off = off;
        #1;
        chk(r, rd_data, exp);
    endtask

    task automatic clr_err(input string r);
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk(r, {31'h0, cfg_err}, 32'h0);
    endtask

    task automatic do_reset(input logic [7:0] b, input logic w64, input logic m, input logic [2:0] c);
        @(negedge clk);
        rst_n = 1'b0; cap_base = b; strap_is64 = w64; strap_mask = m; strap_mmc = c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        #(8ns * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        // ---- configuration A: base 0x40, 32-bit, masking, capable count 2
        do_reset(8'h40, 1'b0, 1'b1, 3'd2);
        expect_pub("R1", 0, 8'h00, 8'h00, 0, 3'd0, 8'h00, 0);
        chk("R1 cap_len", {27'h0, cap_len}, 32'd20);
        rd_chk("R2 ctl reset", 8'h42, 32'h104);

        cfg_wr(8'h44, 3'd4, 32'hFEE0300C);
        cfg_wr(8'h48, 3'd2, 32'h0121);
        rd_chk("R3 addr-lo", 8'h44, 32'hFEE0300C);
        rd_chk("R3 data 32-bit", 8'h48, 32'h0121);
        expect_pub("R7 no publish while disabled", 0, 8'h00, 8'h00, 0, 3'd0, 8'h00, 0);

        // enable with timing probe
        @(negedge clk);
        wr_en = 1'b1; wr_off = 8'h42; wr_len = 3'd2; wr_data = 32'h21;
        @(negedge clk);
        wr_en = 1'b0;
        chk("R7 not yet published", {31'h0, msi_en}, 32'h0);
        @(negedge clk);
        expect_pub("R6 logical enable", 1, 8'h21, 8'd4, 1, 3'd1, 8'h03, 0);
        rd_chk("R2 ctl enabled", 8'h42, 32'h125);

        cfg_wr(8'h44, 3'd4, 32'hFEE05004);
        expect_pub("R9 addr rewrite", 1, 8'h21, 8'd4, 0, 3'd1, 8'h05, 0);

        cfg_wr(8'h44, 3'd2, 32'h0);
        expect_pub("R4 short addr write", 1, 8'h21, 8'd4, 0, 3'd1, 8'h05, 1);
        rd_chk("R4 addr unchanged", 8'h44, 32'hFEE05004);
        clr_err("R11 clear");

        cfg_wr(8'h48, 3'd2, 32'h0030);
        expect_pub("R10 vector change", 1, 8'h21, 8'd4, 0, 3'd1, 8'h05, 1);
        rd_chk("R10 data unchanged", 8'h48, 32'h0121);
        clr_err("R11 clear");

        cfg_wr(8'h48, 3'd2, 32'h0021);
        expect_pub("R9 data rewrite", 1, 8'h21, 8'd4, 0, 3'd0, 8'h05, 0);

        cfg_wr(8'h48, 3'd2, 32'h8021);
        expect_pub("R5 level trigger", 1, 8'h21, 8'd4, 0, 3'd0, 8'h05, 1);
        repeat (5) @(negedge clk);
        chk("R11 sticky", {31'h0, cfg_err}, 32'h1);
        clr_err("R11 clear");
        cfg_wr(8'h48, 3'd2, 32'h0021);
        expect_pub("R9 recheck pass", 1, 8'h21, 8'd4, 0, 3'd0, 8'h05, 0);

        cfg_wr(8'h42, 3'd2, 32'h0020);
        expect_pub("R8 disable", 0, 8'h21, 8'd4, 0, 3'd0, 8'h05, 0);

        cfg_wr(8'h41, 3'd1, 32'hFF);
        expect_pub("R4 below control", 0, 8'h21, 8'd4, 0, 3'd0, 8'h05, 1);
        rd_chk("R4 ctl untouched", 8'h42, 32'h124);
        clr_err("R11 clear");
        cfg_wr(8'h42, 3'd4, 32'h21);
        expect_pub("R4 ctl len 4", 0, 8'h21, 8'd4, 0, 3'd0, 8'h05, 1);
        rd_chk("R4 ctl unchanged", 8'h42, 32'h124);
        clr_err("R11 clear");

        cfg_wr(8'h4C, 3'd4, 32'h3);
        chk("R3 mask write ok", {31'h0, cfg_err}, 32'h0);
        rd_chk("R3 mask readback", 8'h4C, 32'h3);
        cfg_wr(8'h4C, 3'd2, 32'h0);
        chk("R4 mask len 2", {31'h0, cfg_err}, 32'h1);
        clr_err("R11 clear");
        cfg_wr(8'h50, 3'd4, 32'h1);
        chk("R4 pending write", {31'h0, cfg_err}, 32'h1);
        rd_chk("R3 pending zero", 8'h50, 32'h0);
        clr_err("R11 clear");

        cfg_wr(8'h42, 3'd2, 32'h0031);
        expect_pub("R5 count over capable", 0, 8'h21, 8'd4, 0, 3'd0, 8'h05, 1);
        cfg_wr(8'h42, 3'd2, 32'h0000);
        clr_err("R11 clear");

        cfg_wr(8'h48, 3'd2, 32'h000F);
        cfg_wr(8'h42, 3'd2, 32'h0001);
        expect_pub("R5 vector 0x0F", 0, 8'h21, 8'd4, 0, 3'd0, 8'h05, 1);
        cfg_wr(8'h42, 3'd2, 32'h0000);
        clr_err("R11 clear");
        cfg_wr(8'h48, 3'd2, 32'h00FF);
        cfg_wr(8'h42, 3'd2, 32'h0001);
        expect_pub("R5 vector 0xFF", 0, 8'h21, 8'd4, 0, 3'd0, 8'h05, 1);
        cfg_wr(8'h42, 3'd2, 32'h0000);
        clr_err("R11 clear");
        cfg_wr(8'h48, 3'd2, 32'h00FE);
        cfg_wr(8'h42, 3'd2, 32'h0001);
        expect_pub("R5 vector 0xFE accepted", 1, 8'hFE, 8'd1, 0, 3'd0, 8'h05, 0);
        cfg_wr(8'h42, 3'd2, 32'h0000);
        expect_pub("R8 disable keeps fields", 0, 8'hFE, 8'd1, 0, 3'd0, 8'h05, 0);

        cfg_wr(8'h44, 3'd4, 32'hFED03000);
        cfg_wr(8'h48, 3'd2, 32'h0021);
        cfg_wr(8'h42, 3'd2, 32'h0001);
        expect_pub("R5 bad header", 0, 8'hFE, 8'd1, 0, 3'd0, 8'h05, 1);
        cfg_wr(8'h42, 3'd2, 32'h0000);
        clr_err("R11 clear");
        cfg_wr(8'h44, 3'd4, 32'hFEE03010);
        cfg_wr(8'h42, 3'd2, 32'h0001);
        expect_pub("R5 mbz bit 4", 0, 8'hFE, 8'd1, 0, 3'd0, 8'h05, 1);
        cfg_wr(8'h42, 3'd2, 32'h0000);
        clr_err("R11 clear");
        cfg_wr(8'h44, 3'd4, 32'hFEE03001);
        cfg_wr(8'h42, 3'd2, 32'h0001);
        expect_pub("R5 mbz bit 0", 0, 8'hFE, 8'd1, 0, 3'd0, 8'h05, 1);
        cfg_wr(8'h42, 3'd2, 32'h0000);
        clr_err("R11 clear");
        cfg_wr(8'h44, 3'd4, 32'hFEE03008);
        cfg_wr(8'h48, 3'd2, 32'h0221);
        cfg_wr(8'h42, 3'd2, 32'h0001);
        expect_pub("R5 delivery 2", 0, 8'hFE, 8'd1, 0, 3'd0, 8'h05, 1);
        cfg_wr(8'h42, 3'd2, 32'h0000);
        clr_err("R11 clear");
        cfg_wr(8'h48, 3'd2, 32'h0021);
        cfg_wr(8'h42, 3'd2, 32'h0001);
        expect_pub("R6 hint only is physical", 1, 8'h21, 8'd1, 0, 3'd0, 8'h03, 0);

        // error and clear in the same cycle: error wins
        @(negedge clk);
        wr_en = 1'b1; wr_off = 8'h44; wr_len = 3'd1; wr_data = 32'h0; err_clr = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; err_clr = 1'b0;
        chk("R11 set beats clear", {31'h0, cfg_err}, 32'h1);
        clr_err("R11 clear");

        // ---- configuration B: base 0x60, 64-bit, no masking, capable count 0
        do_reset(8'h60, 1'b1, 1'b0, 3'd0);
        chk("R3 cap_len 64-bit", {27'h0, cap_len}, 32'd14);
        rd_chk("R2 ctl straps", 8'h62, 32'h080);
        cfg_wr(8'h68, 3'd4, 32'h1);
        cfg_wr(8'h64, 3'd4, 32'hFEE00000);
        cfg_wr(8'h6C, 3'd2, 32'h0010);
        cfg_wr(8'h62, 3'd2, 32'h0001);
        expect_pub("R5 upper address nonzero", 0, 8'h00, 8'h00, 0, 3'd0, 8'h00, 1);
        cfg_wr(8'h62, 3'd2, 32'h0000);
        clr_err("R11 clear");
        cfg_wr(8'h68, 3'd4, 32'h0);
        cfg_wr(8'h62, 3'd2, 32'h0001);
        expect_pub("R3 64-bit layout vector 0x10", 1, 8'h10, 8'd1, 0, 3'd0, 8'h00, 0);
        rd_chk("R3 data at base+0xC", 8'h6C, 32'h0010);
        rd_chk("R3 addr-hi at base+8", 8'h68, 32'h0);
        cfg_wr(8'h70, 3'd4, 32'h1);
        chk("R3 no mask register", {31'h0, cfg_err}, 32'h1);

        done = 1;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule